// File: doc/BRIEF.md
# Credit-Exchange Dual-Clock FIFO

This block carries data words from one clock domain to another. It does not pass Gray-coded pointers across the boundary. Each side keeps its own count of how many words the FIFO holds, and that count always errs on the safe side. The writer's count never falls below the true number of stored words. The reader's count never rises above it. The two counts are kept in step by short messages. Each message says how many words were added, or how many were taken out, since the previous message.

Each direction has a message channel. The channel is driven by a toggle request that the receiving domain synchronizes. A delta value travels with the request and is held steady until a toggle acknowledge comes back. While a message is waiting for its acknowledge, the sender keeps counting its local events. When the acknowledge arrives, it sends all of those events as one new delta. Because of this, bursts are never lost, whichever clock is faster. More synchronizer stages make the crossing more robust. Their only cost is a slower recovery of the full and empty flags.

Storage is a small register array. It is written on the write clock and read through a show-ahead port: the oldest word is presented whenever the FIFO is not empty, and a read pops it.

Top module: `hsc_afifo`

## Requirements
- R1: After both resets, wr_full is 0 and rd_empty is 1.
- R2: Words leave in the order in which they were accepted. Whenever rd_empty is 0, rd_data shows the oldest word not yet read.
- R3: A write attempted while wr_full is 1 is dropped. It is not stored and never appears at rd_data.
- R4: A read attempted while rd_empty is 1 has no effect. No word is skipped or lost.
- R5: wr_full is 0 only while fewer than DEPTH words are stored. Starting from empty with the reader idle, exactly DEPTH back-to-back writes are accepted before wr_full rises.
- R6: rd_empty is 0 only while at least one word is stored.
- R7: Every accepted word is delivered, at any ratio between the two clock rates. This includes back-to-back writes while the read clock runs at half the write rate or slower, and the reverse ratio.
- R8: A delta message always reports at least one event. The delta value changes only together with its request toggle, and it holds until the acknowledge returns.
- R9: Once both sides have been idle for a bounded number of cycles, the flags match the true fill: rd_empty clears when words are held, and wr_full clears after the FIFO has been drained.
- R10: Both occupancy counts stay within 0 to DEPTH.
- R11: A read that falls in the same read-clock cycle as an incoming write delta leaves the read count at count plus delta minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side reset, active low |
| wr_en | input | 1 | Write request; accepted when wr_full is 0 |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | Write side sees no free slot |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side reset, active low |
| rd_en | input | 1 | Pop request; accepted when rd_empty is 0 |
| rd_data | output | DATA_W | Oldest stored word (valid while rd_empty is 0) |
| rd_empty | output | 1 | Read side sees no stored word |

## Verification
A lost or duplicated delta makes the two counts drift apart, and the drift shows up at the ports.
- If the reader's count runs high, a stale or repeated word appears at rd_data. This is seen at the first read of that word, which is compared against the bench's queue.
- If the writer's count runs low, the bench sees wr_full at 0 while DEPTH words are stored. This is caught on the very next write cycle.
- If credits are lost in either direction, one of the two flags stays stuck. A fill-and-drain pass catches this within a few dozen cycles, because the accepted and drained counts will not equal DEPTH, or because the flags will not settle.

// File: rtl/hsc_afifo_pkg.sv
package hsc_afifo_pkg;

    // Pointer width for a storage depth; never narrower than one bit.
    function automatic int ptr_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    // Counter width able to hold the value DEPTH itself.
    function automatic int cnt_width(input int depth);
        return ptr_width(depth) + 1;
    endfunction

endpackage

// File: rtl/hsc_sync.sv
module hsc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[0] <= 1'b0;
                else        chain_q[0] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= 1'b0;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hsc_delta_tx.sv
module hsc_delta_tx #(
    parameter int CW          = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_i,
    input  logic          ack_tgl_i,
    output logic          req_tgl_o,
    output logic [CW-1:0] delta_o
);
    typedef struct packed {
        logic [CW-1:0] ev;     // running event count (wraps)
        logic [CW-1:0] sent;   // event count at the last message
        logic [CW-1:0] delta;  // value on the wire, held while pending
        logic          req;    // request toggle
    } tx_t;

    tx_t  tx_d, tx_q;
    logic ack_s;
    logic idle;

    hsc_sync #(.STAGES(SYNC_STAGES)) ack_sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ack_tgl_i),
        .q_o   (ack_s)
    );

    assign idle = (ack_s == tx_q.req);

    always_comb begin
        tx_d    = tx_q;
        tx_d.ev = tx_q.ev + {{(CW-1){1'b0}}, evt_i};
        if (idle && (tx_q.ev != tx_q.sent)) begin
            tx_d.delta = tx_q.ev - tx_q.sent;
            tx_d.sent  = tx_q.ev;
            tx_d.req   = ~tx_q.req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign req_tgl_o = tx_q.req;
    assign delta_o   = tx_q.delta;
endmodule

// File: rtl/hsc_delta_rx.sv
module hsc_delta_rx #(
    parameter int CW          = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_tgl_i,
    input  logic [CW-1:0] delta_i,
    output logic          ack_tgl_o,
    output logic [CW-1:0] delta_o
);
    typedef struct packed {
        logic seen;  // last request level taken in; doubles as acknowledge
    } rx_t;

    rx_t  rx_d, rx_q;
    logic req_s;
    logic take;

    hsc_sync #(.STAGES(SYNC_STAGES)) req_sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (req_tgl_i),
        .q_o   (req_s)
    );

    assign take = (req_s != rx_q.seen);

    always_comb begin
        rx_d      = rx_q;
        rx_d.seen = req_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    // Delta is only looked at once the synchronized toggle has moved.
    assign delta_o   = take ? delta_i : '0;
    assign ack_tgl_o = rx_q.seen;
endmodule

// File: rtl/hsc_regarray.sv
module hsc_regarray #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    parameter int AW     = 3
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/hsc_afifo.sv
module hsc_afifo #(
    parameter int DATA_W      = 8,
    parameter int DEPTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty
);
    localparam int AW = hsc_afifo_pkg::ptr_width(DEPTH);
    localparam int CW = hsc_afifo_pkg::cnt_width(DEPTH);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [CW-1:0] cnt;
    } side_t;

    side_t w_d, w_q;
    side_t r_d, r_q;

    logic          wr_accept, rd_accept;
    logic          add_req_tgl, add_ack_tgl;
    logic [CW-1:0] add_delta, add_val;
    logic          rm_req_tgl, rm_ack_tgl;
    logic [CW-1:0] rm_delta, rm_val;

    // ---------------- write domain ----------------
    assign wr_full   = (w_q.cnt == FULL_CNT);
    assign wr_accept = wr_en && !wr_full;

    always_comb begin
        w_d     = w_q;
        w_d.cnt = w_q.cnt + {{(CW-1){1'b0}}, wr_accept} - rm_val;
        if (wr_accept) begin
            w_d.ptr = (w_q.ptr == LAST_PTR) ? '0 : w_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) w_q <= '0;
        else           w_q <= w_d;
    end

    hsc_delta_tx #(.CW(CW), .SYNC_STAGES(SYNC_STAGES)) add_tx_i (
        .clk       (wr_clk),
        .rst_n     (wr_rst_n),
        .evt_i     (wr_accept),
        .ack_tgl_i (add_ack_tgl),
        .req_tgl_o (add_req_tgl),
        .delta_o   (add_delta)
    );

    hsc_delta_rx #(.CW(CW), .SYNC_STAGES(SYNC_STAGES)) rm_rx_i (
        .clk       (wr_clk),
        .rst_n     (wr_rst_n),
        .req_tgl_i (rm_req_tgl),
        .delta_i   (rm_delta),
        .ack_tgl_o (rm_ack_tgl),
        .delta_o   (rm_val)
    );

    // ---------------- storage ----------------
    hsc_regarray #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) store_i (
        .wclk  (wr_clk),
        .we    (wr_accept),
        .waddr (w_q.ptr),
        .wdata (wr_data),
        .raddr (r_q.ptr),
        .rdata (rd_data)
    );

    // ---------------- read domain ----------------
    assign rd_empty  = (r_q.cnt == '0);
    assign rd_accept = rd_en && !rd_empty;

    always_comb begin
        r_d     = r_q;
        r_d.cnt = r_q.cnt + add_val - {{(CW-1){1'b0}}, rd_accept};
        if (rd_accept) begin
            r_d.ptr = (r_q.ptr == LAST_PTR) ? '0 : r_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) r_q <= '0;
        else           r_q <= r_d;
    end

    hsc_delta_rx #(.CW(CW), .SYNC_STAGES(SYNC_STAGES)) add_rx_i (
        .clk       (rd_clk),
        .rst_n     (rd_rst_n),
        .req_tgl_i (add_req_tgl),
        .delta_i   (add_delta),
        .ack_tgl_o (add_ack_tgl),
        .delta_o   (add_val)
    );

    hsc_delta_tx #(.CW(CW), .SYNC_STAGES(SYNC_STAGES)) rm_tx_i (
        .clk       (rd_clk),
        .rst_n     (rd_rst_n),
        .evt_i     (rd_accept),
        .ack_tgl_i (rm_ack_tgl),
        .req_tgl_o (rm_req_tgl),
        .delta_o   (rm_delta)
    );
endmodule

// File: rtl/hsc_afifo_chk.sv
module hsc_afifo_chk #(
    parameter int DEPTH = 8,
    parameter int AW    = 3,
    parameter int CW    = 4
) (
    input logic          wr_clk,
    input logic          wr_rst_n,
    input logic          wr_en,
    input logic          wr_full,
    input logic [AW-1:0] w_ptr,
    input logic [CW-1:0] w_cnt,
    input logic          add_req,
    input logic [CW-1:0] add_delta,
    input logic          rd_clk,
    input logic          rd_rst_n,
    input logic          rd_en,
    input logic          rd_empty,
    input logic [AW-1:0] r_ptr,
    input logic [CW-1:0] r_cnt,
    input logic          rm_req,
    input logic [CW-1:0] rm_delta
);
    localparam logic [CW-1:0] LIMIT = CW'(DEPTH);

    AST_WCNT_BOUNDED: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        w_cnt <= LIMIT);  // R10
    AST_RCNT_BOUNDED: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        r_cnt <= LIMIT);  // R10
    AST_FULL_DROPS_WRITE: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && wr_full) |=> $stable(w_ptr));  // R3
    AST_EMPTY_IGNORES_READ: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_en && rd_empty) |=> $stable(r_ptr));  // R4
    AST_ADD_DELTA_WITH_REQ: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !$stable(add_delta) |-> !$stable(add_req));  // R8
    AST_RM_DELTA_WITH_REQ: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !$stable(rm_delta) |-> !$stable(rm_req));  // R8
    AST_ADD_DELTA_NONZERO: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !$stable(add_req) |-> (add_delta != '0));  // R8
    AST_RM_DELTA_NONZERO: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !$stable(rm_req) |-> (rm_delta != '0));  // R8
endmodule

bind hsc_afifo hsc_afifo_chk #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) chk_i (
    .wr_clk    (wr_clk),
    .wr_rst_n  (wr_rst_n),
    .wr_en     (wr_en),
    .wr_full   (wr_full),
    .w_ptr     (w_q.ptr),
    .w_cnt     (w_q.cnt),
    .add_req   (add_req_tgl),
    .add_delta (add_delta),
    .rd_clk    (rd_clk),
    .rd_rst_n  (rd_rst_n),
    .rd_en     (rd_en),
    .rd_empty  (rd_empty),
    .r_ptr     (r_q.ptr),
    .r_cnt     (r_q.cnt),
    .rm_req    (rm_req_tgl),
    .rm_delta  (rm_delta)
);

// File: tb/hsc_afifo_tb_top.sv
`timescale 1ns/1ps
module hsc_afifo_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;
    localparam int DEPTH      = 8;

    logic              wr_clk = 0, rd_clk = 0;
    logic              wr_rst_n = 0, rd_rst_n = 0;
    logic              wr_en = 0, rd_en = 0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic              wr_full, rd_empty;

    int wr_half = CLK_PERIOD / 2;
    int rd_half = CLK_PERIOD + 1;

    always #(wr_half) wr_clk = ~wr_clk;
    always #(rd_half) rd_clk = ~rd_clk;

    hsc_afifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SYNC_STAGES(2)) dut_i (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wr_full  (wr_full),
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rd_empty (rd_empty)
    );

    // Reference model: words accepted but not yet popped, oldest first.
    logic [DATA_W-1:0] model_q[$];
    logic [DATA_W-1:0] next_wval = 8'h01;
    int checks = 0, failures = 0;
    int wr_acc = 0, rd_acc = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One write-clock cycle; acceptance decided from wr_full before the edge.
    task automatic wr_cycle(input bit en);
        @(negedge wr_clk);
        if (!wr_full) chk(model_q.size() < DEPTH, "R5 free slot while not full", model_q.size(), DEPTH - 1);
        wr_en   = en;
        wr_data = next_wval;
        if (en && !wr_full) begin
            model_q.push_back(next_wval);
            next_wval = next_wval + 1'b1;
            wr_acc++;
        end
    endtask

    // One read-clock cycle; checks the presented head, then decides the pop.
    task automatic rd_cycle(input bit en);
        @(negedge rd_clk);
        if (!rd_empty) begin
            chk(model_q.size() > 0, "R6 word present while not empty", model_q.size(), 1);
            if (model_q.size() > 0)
                chk(rd_data == model_q[0], "R2 order", rd_data, model_q[0]);
        end
        rd_en = en;
        if (en && !rd_empty && model_q.size() > 0) begin
            void'(model_q.pop_front());
            rd_acc++;
        end
    endtask

    task automatic write_items(input int n, input int pct);
        int target;
        target = wr_acc + n;
        while (wr_acc < target) wr_cycle(($urandom % 100) < pct);
        wr_cycle(0);
    endtask

    task automatic read_items(input int target, input int pct);
        int guard;
        guard = 0;
        while (rd_acc < target && guard < 20000) begin
            rd_cycle(($urandom % 100) < pct);
            guard++;
        end
        rd_cycle(0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R7 actual=%0d expected=%0d", rd_acc, wr_acc);
            finish_run();
        end
    end

    initial begin
        int base;
        repeat (4) @(negedge rd_clk);
        @(negedge wr_clk) wr_rst_n = 1;
        @(negedge rd_clk) rd_rst_n = 1;
        @(negedge wr_clk);
        chk(wr_full == 1'b0, "R1 wr_full after reset", wr_full, 0);
        chk(rd_empty == 1'b1, "R1 rd_empty after reset", rd_empty, 1);

        // R4: pops while empty have no effect.
        repeat (6) rd_cycle(1);
        rd_cycle(0);
        chk(rd_acc == 0, "R4 pops taken while empty", rd_acc, 0);
        chk(rd_empty == 1'b1, "R4 still empty", rd_empty, 1);

        // R5/R3: reader idle; exactly DEPTH of DEPTH+3 writes taken.
        repeat (DEPTH + 3) wr_cycle(1);
        wr_cycle(0);
        chk(wr_acc == DEPTH, "R5 writes accepted to full", wr_acc, DEPTH);
        chk(wr_full == 1'b1, "R3 full holds after extra writes", wr_full, 1);
        repeat (12) @(negedge rd_clk);
        chk(rd_empty == 1'b0, "R9 empty clears after writes", rd_empty, 0);
        read_items(DEPTH, 100);
        chk(rd_acc == DEPTH, "R3 only accepted words drained", rd_acc, DEPTH);
        repeat (20) @(negedge wr_clk);
        chk(wr_full == 1'b0, "R9 full clears after drain", wr_full, 0);
        chk(rd_empty == 1'b1, "R9 empty after drain", rd_empty, 1);

        // R7/R11: streaming, write clock faster; pops meet incoming credit.
        base = rd_acc;
        fork
            write_items(200, 70);
            read_items(base + 200, 60);
        join
        chk(rd_acc == base + 200, "R7 fast writer stream delivered", rd_acc - base, 200);

        // R7: ratio reversed, read clock faster.
        wr_half = 15; rd_half = 3;
        base = rd_acc;
        fork
            write_items(200, 80);
            read_items(base + 200, 50);
        join
        chk(rd_acc == base + 200, "R7 fast reader stream delivered", rd_acc - base, 200);

        // R7: back-to-back writes, reader more than twice slower.
        wr_half = 4; rd_half = 9;
        base = rd_acc;
        fork
            write_items(150, 100);
            read_items(base + 150, 100);
        join
        chk(rd_acc == base + 150, "R7 burst under slow reader", rd_acc - base, 150);
        chk(model_q.size() == 0, "R7 model drained", model_q.size(), 0);
        repeat (30) @(negedge wr_clk);
        chk(wr_full == 1'b0, "R9 full clear at end", wr_full, 0);
        chk(rd_empty == 1'b1, "R9 empty at end", rd_empty, 1);

        done = 1;
        finish_run();
    end
endmodule